// File: doc/BRIEF.md
# Write-back data cache controller

This block is a small direct-mapped data cache placed between a processor load/store port and a word-addressed memory port. Stores land only in the cache and mark their line as modified; memory sees modified data only when the line is evicted to make room for a miss, or when software asks for a write-back through the maintenance port. A line written back is dropped, not kept.

Each of the 16 lines holds 4 words and has one of three states: invalid, valid clean or valid dirty. A line in any state but invalid may hit. Reset clears only the control logic. Line states and contents survive reset, so software starts by invalidating every index through the maintenance port.

Requests are single-cycle pulses taken while `cpu_busy` is low. Hits finish without a stall. Misses, victim write-backs and dirty write-back commands raise `cpu_busy` until they complete. The memory side uses a req/ack handshake with one word per acknowledge.

Top module: `wbc_cache`

## Requirements
- R1: A store that hits writes only the cache and causes no memory request. A later load of the same word returns the stored value.
- R2: A load that hits returns its word with `cpu_done` one cycle after the request is taken, and no memory request is made.
- R3: `mem_req` is high only while `cpu_busy` is high. While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable. After reset `cpu_busy`, `cpu_done`, `mnt_done` and `mem_req` are low.
- R4: A load miss whose victim is not dirty performs exactly 4 memory reads, at word addresses {tag, index, 0..3}, and no writes. It returns the requested word, and the line becomes valid clean. The byte address splits into tag [31:8], index [7:4], word [3:2] and byte [1:0]. `mem_addr` is the byte address shifted right by 2.
- R5: A miss whose victim is dirty first writes the 4 victim words to the victim's address, and only then starts the 4 refill reads.
- R6: A store miss refills the line, merges the store word into it, and leaves the line valid dirty. The merged word reaches memory when the line is later written back.
- R7: A clean victim is dropped without any memory write.
- R8: The maintenance command with `mnt_op`=0 makes the line at `mnt_idx` invalid without writing it, even if it is dirty. The next access to that line misses. An invalid line never hits. `mnt_done` pulses once when the command completes.
- R9: The maintenance command with `mnt_op`=1 writes the 4 words of a dirty line at `mnt_idx` to memory and then invalidates the line. On a clean or invalid line it only invalidates, with no write. `mnt_done` pulses once when the command completes, and `cpu_done` never pulses in the same cycle.
- R10: Reset does not change line states or contents. A line loaded before a reset still hits after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control logic |
| cpu_req | input | 1 | One-cycle request pulse, taken while `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | A miss or write-back sequence is in progress |
| mnt_req | input | 1 | Maintenance command pulse; has priority over `cpu_req` |
| mnt_op | input | 1 | 0 = invalidate, 1 = write back and invalidate |
| mnt_idx | input | log2(LINES) | Target line index |
| mnt_done | output | 1 | One-cycle completion pulse of a command |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes one word transfer |

## Verification
The assertions check on every cycle that memory traffic happens only during busy sequences and holds steady until acknowledged. They also check that eviction beats are writes and refill beats are reads, that a hit is never followed by a memory request, that an invalid line never hits, and that busy ends with a completion pulse. Only the bench scenarios can show the data path. These cover values merged on a store miss, dirty data reaching the right memory words, the writes-before-reads order of a dirty eviction, the difference between discarding and writing back a dirty line, and lines surviving a reset.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    LS_INV   = 2'b00,
    LS_CLEAN = 2'b01,
    LS_DIRTY = 2'b11
  } line_state_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL
  } ctl_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
  import wbc_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_state_e      rd_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_state_e      wr_state
);

  // No reset on purpose: line states survive reset.
  logic [TAG_W-1:0] tag_q [LINES];
  line_state_e      st_q  [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      st_q[wr_idx]  <= wr_state;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int DEPTH = LINES * WORDS,
  localparam int A_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [A_W-1:0]    addr,
  output logic [DATA_W-1:0] rdata,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - 2,
  localparam int MEM_AW = ADDR_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   cpu_done,
  output logic                   cpu_busy,
  input  logic                   mnt_req,
  input  logic                   mnt_op,
  input  logic [IDX_W-1:0]       mnt_idx,
  output logic                   mnt_done,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [MEM_AW-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  output logic [IDX_W-1:0]       ts_rd_idx,
  input  logic [TAG_W-1:0]       ts_rd_tag,
  input  line_state_e            ts_rd_state,
  output logic                   ts_wr_en,
  output logic [IDX_W-1:0]       ts_wr_idx,
  output logic [TAG_W-1:0]       ts_wr_tag,
  output line_state_e            ts_wr_state,
  output logic [IDX_W+OFF_W-1:0] ds_addr,
  input  logic [DATA_W-1:0]      ds_rdata,
  output logic                   ds_wr_en,
  output logic [DATA_W-1:0]      ds_wdata,
  output logic                   ev_hit,
  output logic                   ev_miss,
  output logic                   ev_evict_beat,
  output logic                   ev_fill_beat
);

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[2+OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] addr_off(input logic [ADDR_W-1:0] a);
    return a[2 +: OFF_W];
  endfunction

  function automatic logic [MEM_AW-1:0] word_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [OFF_W-1:0] o);
    return {t, i, o};
  endfunction

  ctl_state_e        state_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              for_mnt_q;
  logic [TAG_W-1:0]  lat_tag_q;
  logic [IDX_W-1:0]  lat_idx_q;
  logic [OFF_W-1:0]  lat_off_q;
  logic              lat_we_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cpu_done_q;
  logic              mnt_done_q;

  logic idle, accept_mnt, accept_cpu, line_live, last_beat, mnt_evict;

  assign idle       = (state_q == ST_IDLE);
  assign accept_mnt = idle && mnt_req;
  assign accept_cpu = idle && cpu_req && !mnt_req;
  assign ts_rd_idx  = !idle ? lat_idx_q : (mnt_req ? mnt_idx : addr_idx(cpu_addr));
  assign line_live  = (ts_rd_state != LS_INV);
  assign ev_hit     = accept_cpu && line_live && (ts_rd_tag == addr_tag(cpu_addr));
  assign ev_miss    = accept_cpu && !ev_hit;
  assign mnt_evict  = mnt_op && (ts_rd_state == LS_DIRTY);
  assign last_beat  = (cnt_q == OFF_W'(WORDS - 1));
  assign ev_evict_beat = (state_q == ST_EVICT) && mem_ack;
  assign ev_fill_beat  = (state_q == ST_FILL) && mem_ack;

  assign mem_req   = !idle;
  assign mem_we    = (state_q == ST_EVICT);
  assign mem_addr  = (state_q == ST_EVICT) ? word_addr(ts_rd_tag, lat_idx_q, cnt_q)
                                           : word_addr(lat_tag_q, lat_idx_q, cnt_q);
  assign mem_wdata = ds_rdata;
  assign ds_addr   = idle ? {addr_idx(cpu_addr), addr_off(cpu_addr)} : {lat_idx_q, cnt_q};

  assign cpu_rdata = rdata_q;
  assign cpu_done  = cpu_done_q;
  assign mnt_done  = mnt_done_q;
  assign cpu_busy  = !idle;

  always_comb begin
    ts_wr_en    = 1'b0;
    ts_wr_idx   = lat_idx_q;
    ts_wr_tag   = ts_rd_tag;
    ts_wr_state = LS_INV;
    ds_wr_en    = 1'b0;
    ds_wdata    = mem_rdata;
    if (accept_mnt && !mnt_evict) begin
      ts_wr_en  = 1'b1;
      ts_wr_idx = mnt_idx;
    end
    if (ev_hit && cpu_we) begin
      ts_wr_en    = 1'b1;
      ts_wr_idx   = addr_idx(cpu_addr);
      ts_wr_state = LS_DIRTY;
      ds_wr_en    = 1'b1;
      ds_wdata    = cpu_wdata;
    end
    if (ev_evict_beat && last_beat && for_mnt_q) begin
      ts_wr_en = 1'b1;
    end
    if (ev_fill_beat) begin
      ds_wr_en = 1'b1;
      if (lat_we_q && (cnt_q == lat_off_q)) ds_wdata = lat_wdata_q;
      if (last_beat) begin
        ts_wr_en    = 1'b1;
        ts_wr_tag   = lat_tag_q;
        ts_wr_state = lat_we_q ? LS_DIRTY : LS_CLEAN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      for_mnt_q   <= 1'b0;
      lat_tag_q   <= '0;
      lat_idx_q   <= '0;
      lat_off_q   <= '0;
      lat_we_q    <= 1'b0;
      lat_wdata_q <= '0;
      rdata_q     <= '0;
      cpu_done_q  <= 1'b0;
      mnt_done_q  <= 1'b0;
    end else begin
      cpu_done_q <= 1'b0;
      mnt_done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (accept_mnt) begin
            lat_idx_q <= mnt_idx;
            if (mnt_evict) begin
              state_q   <= ST_EVICT;
              for_mnt_q <= 1'b1;
            end else begin
              mnt_done_q <= 1'b1;
            end
          end else if (ev_hit) begin
            cpu_done_q <= 1'b1;
            if (!cpu_we) rdata_q <= ds_rdata;
          end else if (ev_miss) begin
            lat_tag_q   <= addr_tag(cpu_addr);
            lat_idx_q   <= addr_idx(cpu_addr);
            lat_off_q   <= addr_off(cpu_addr);
            lat_we_q    <= cpu_we;
            lat_wdata_q <= cpu_wdata;
            for_mnt_q   <= 1'b0;
            state_q     <= (ts_rd_state == LS_DIRTY) ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: begin
          if (mem_ack) begin
            cnt_q <= cnt_q + OFF_W'(1);
            if (last_beat) begin
              if (for_mnt_q) begin
                state_q    <= ST_IDLE;
                mnt_done_q <= 1'b1;
              end else begin
                state_q <= ST_FILL;
              end
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            cnt_q <= cnt_q + OFF_W'(1);
            if (cnt_q == lat_off_q) rdata_q <= mem_rdata;
            if (last_beat) begin
              state_q    <= ST_IDLE;
              cpu_done_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - 2,
  localparam int MEM_AW = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  input  logic              mnt_req,
  input  logic              mnt_op,
  input  logic [IDX_W-1:0]  mnt_idx,
  output logic              mnt_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  logic [IDX_W-1:0]       ts_rd_idx, ts_wr_idx;
  logic [TAG_W-1:0]       ts_rd_tag, ts_wr_tag;
  line_state_e            ts_rd_state, ts_wr_state;
  logic                   ts_wr_en;
  logic [IDX_W+OFF_W-1:0] ds_addr;
  logic [DATA_W-1:0]      ds_rdata, ds_wdata;
  logic                   ds_wr_en;
  logic                   ev_hit, ev_miss, ev_evict_beat, ev_fill_beat;

  wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rd_idx(ts_rd_idx), .rd_tag(ts_rd_tag), .rd_state(ts_rd_state),
    .wr_en(ts_wr_en), .wr_idx(ts_wr_idx), .wr_tag(ts_wr_tag), .wr_state(ts_wr_state)
  );

  wbc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .addr(ds_addr), .rdata(ds_rdata), .wr_en(ds_wr_en), .wdata(ds_wdata)
  );

  wbc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .mnt_req(mnt_req), .mnt_op(mnt_op), .mnt_idx(mnt_idx), .mnt_done(mnt_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ts_rd_idx(ts_rd_idx), .ts_rd_tag(ts_rd_tag), .ts_rd_state(ts_rd_state),
    .ts_wr_en(ts_wr_en), .ts_wr_idx(ts_wr_idx), .ts_wr_tag(ts_wr_tag), .ts_wr_state(ts_wr_state),
    .ds_addr(ds_addr), .ds_rdata(ds_rdata), .ds_wr_en(ds_wr_en), .ds_wdata(ds_wdata),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_evict_beat(ev_evict_beat), .ev_fill_beat(ev_fill_beat)
  );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker
  import wbc_pkg::*;
#(
  parameter int MEM_AW = 30,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              mnt_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              ev_hit,
  input logic              ev_evict_beat,
  input logic              ev_fill_beat,
  input line_state_e       sel_state
);

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_busy);  // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R3

  AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> !mem_req);  // R1

  AST_FILL_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_beat |-> !mem_we);  // R4

  AST_EVICT_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict_beat |-> mem_we);  // R5

  AST_NO_INVALID_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> (sel_state != LS_INV));  // R8

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_done && mnt_done));  // R9

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_busy) |-> (cpu_done || mnt_done));  // R9

endmodule

bind wbc_cache wbc_checker #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .mnt_done(mnt_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ev_hit(ev_hit), .ev_evict_beat(ev_evict_beat),
  .ev_fill_beat(ev_fill_beat), .sel_state(ts_rd_state)
);

// File: tb/tb_wbc_cache.sv
module tb_wbc_cache;
  localparam int AW = 32, DW = 32, MAW = 30, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0, mnt_req = 0, mnt_op = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [IW-1:0] mnt_idx = '0;
  logic [DW-1:0] cpu_rdata, mem_wdata, mem_rdata;
  logic cpu_done, cpu_busy, mnt_done, mem_req, mem_we, mem_ack;
  logic [MAW-1:0] mem_addr;

  wbc_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .mnt_req(mnt_req), .mnt_op(mnt_op), .mnt_idx(mnt_idx), .mnt_done(mnt_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: acknowledges one cycle after a request, logs traffic.
  logic [DW-1:0] mem_img [logic [MAW-1:0]];
  logic ack_r = 1'b0;
  logic [DW-1:0] rdata_r = '0;
  int n_wr = 0, n_rd = 0, rd_seen_wr = -1;
  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;

  function automatic logic [DW-1:0] seed_word(input logic [MAW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0000;
  endfunction

  function automatic logic [DW-1:0] mem_peek(input logic [MAW-1:0] a);
    return mem_img.exists(a) ? mem_img[a] : seed_word(a);
  endfunction

  always @(posedge clk) begin
    if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      if (mem_we) begin
        mem_img[mem_addr] = mem_wdata;
        n_wr++;
      end else begin
        rdata_r <= mem_peek(mem_addr);
        if (rd_seen_wr < 0) rd_seen_wr = n_wr;
        n_rd++;
      end
    end else begin
      ack_r <= 1'b0;
    end
  end

  // Scoreboard: expected CPU-visible contents and pending results.
  logic [DW-1:0] shadow [logic [MAW-1:0]];
  logic [DW-1:0] exp_q [$];
  bit            ld_q  [$];
  string         req_q [$];

  always @(negedge clk) begin
    if (rst_n && cpu_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", cpu_rdata, '0);
      end else begin
        logic [DW-1:0] e;
        bit ld;
        string r;
        e = exp_q.pop_front();
        ld = ld_q.pop_front();
        r = req_q.pop_front();
        if (ld) check(cpu_rdata === e, r, cpu_rdata, e);
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int ewr, input int erd, input string req);
    int wr0, rd0, waits;
    bit saw_busy;
    logic [MAW-1:0] wa;
    wa = a[AW-1:2];
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    if (we) begin
      shadow[wa] = d;
      exp_q.push_back('0);
      ld_q.push_back(1'b0);
    end else begin
      exp_q.push_back(shadow.exists(wa) ? shadow[wa] : mem_peek(wa));
      ld_q.push_back(1'b1);
    end
    req_q.push_back(req);
    wr0 = n_wr; rd0 = n_rd; rd_seen_wr = -1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    waits = 0; saw_busy = 0;
    while (!cpu_done && waits < 200) begin
      if (cpu_busy) saw_busy = 1;
      waits++;
      @(negedge clk);
    end
    check(n_wr - wr0 == ewr, {req, " write count"}, DW'(n_wr - wr0), DW'(ewr));
    check(n_rd - rd0 == erd, {req, " read count"}, DW'(n_rd - rd0), DW'(erd));
    if (ewr == 0 && erd == 0) check(waits == 0, "R2 hit latency", DW'(waits), 0);
    else check(saw_busy, "R3 busy during miss", DW'(saw_busy), 1);
    if (ewr > 0 && erd > 0)
      check(rd_seen_wr - wr0 == ewr, "R5 writes before refill", DW'(rd_seen_wr - wr0), DW'(ewr));
  endtask

  task automatic mnt_cmd(input bit op, input int idx, input int ewr, input string req);
    int wr0, waits;
    logic [MAW-1:0] drop [$];
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    wr0 = n_wr;
    mnt_req = 1'b1; mnt_op = op; mnt_idx = IW'(idx);
    @(negedge clk);
    mnt_req = 1'b0;
    waits = 0;
    while (!mnt_done && waits < 200) begin
      waits++;
      @(negedge clk);
    end
    check(mnt_done, {req, " done pulse"}, DW'(mnt_done), 1);
    check(n_wr - wr0 == ewr, {req, " write count"}, DW'(n_wr - wr0), DW'(ewr));
    if (!op) begin
      foreach (shadow[k]) if (int'(k[5:2]) == idx) drop.push_back(k);
      foreach (drop[j]) shadow.delete(drop[j]);
    end
  endtask

  task automatic check_mem(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    check(mem_peek(a[AW-1:2]) === e, req, mem_peek(a[AW-1:2]), e);
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1010;
  localparam logic [AW-1:0] B = 32'h0000_2014;
  localparam logic [AW-1:0] C = 32'h0000_3028;
  localparam logic [AW-1:0] D = 32'h0000_4034;

  initial begin
    repeat (3) @(negedge clk);
    check(!cpu_busy && !cpu_done && !mnt_done && !mem_req, "R3 reset state",
          {28'd0, cpu_busy, cpu_done, mnt_done, mem_req}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) mnt_cmd(1'b0, i, 0, "R8 invalidate all");

    cpu_op(0, A, '0, 0, 4, "R4 load miss");
    cpu_op(0, A + 4, '0, 0, 0, "R2 load hit");
    cpu_op(1, A + 8, 32'hDEAD_0001, 0, 0, "R1 store hit");
    cpu_op(0, A + 8, '0, 0, 0, "R1 load after store");
    cpu_op(0, B, '0, 4, 4, "R5 dirty victim");
    check_mem(A + 8, 32'hDEAD_0001, "R5 victim data in memory");
    cpu_op(0, A + 8, '0, 0, 4, "R7 clean victim");

    cpu_op(1, C, 32'h0000_BEEF, 0, 4, "R6 store miss");
    cpu_op(0, C, '0, 0, 0, "R6 merged hit");
    mnt_cmd(1'b1, 2, 4, "R9 writeback dirty");
    check_mem(C, 32'h0000_BEEF, "R9 merged word written");
    check_mem(C + 4, seed_word(C[AW-1:2] + 1), "R6 refilled word written");
    cpu_op(0, C, '0, 0, 4, "R9 line invalid after writeback");

    mnt_cmd(1'b1, 1, 0, "R9 writeback clean");
    cpu_op(0, A, '0, 0, 4, "R9 clean line invalidated");

    cpu_op(1, A, 32'h0000_1111, 0, 0, "R1 store hit second");
    mnt_cmd(1'b0, 1, 0, "R8 invalidate dirty");
    cpu_op(0, A, '0, 0, 4, "R8 discarded data");
    check_mem(A, seed_word(A[AW-1:2]), "R8 memory untouched");

    cpu_op(1, D, 32'h0000_7777, 0, 4, "R6 store miss second");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    cpu_op(0, D, '0, 0, 0, "R10 hit after reset");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results seen", DW'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule